// File: doc/BRIEF.md
# Page Write Buffer with Wrapping Offset

This block sits behind the serial command decoder of a byte-wide nonvolatile memory model. When a write command opens, the decoder hands it the start address and whether the write-enable latch was set. Each received data byte is then stored in a page-sized buffer at an offset taken from the low address bits. After each byte that offset steps by one and wraps inside the page, while the upper address bits stay fixed. Sending more bytes than a page holds therefore overwrites bytes that were loaded earlier.

When chip select rises, the decoder reports whether the rise came exactly at the end of a byte. It also supplies an allow signal from the protection logic. Only an aligned rise, with write-enable set, protection allowing and at least one byte loaded, starts programming. The block then streams the whole page to the array write port, one byte per clock in ascending offset order, and fills every offset that was not loaded with all ones. A programmable timer then models the rest of the self-timed write cycle. Busy is held for the whole operation, and a one-cycle pulse at the end tells the decoder to clear its write-enable latch. Any other chip-select rise discards the transaction without a busy period. While busy, every input is ignored.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy`, `arr_we` and `wen_clear` are all low.
- R2: A byte strobed in a transaction lands at the offset equal to the start address's low OFF_W bits plus the number of bytes already strobed, modulo PAGE_BYTES. The array address of every written byte is {start address upper bits, offset}.
- R3: When more than PAGE_BYTES bytes are strobed, the last byte strobed at an offset is the value programmed there.
- R4: Every offset that received no byte in the transaction is programmed with all ones (8'hFF).
- R5: A `cs_rise` with `cs_rise_aligned`=1 and `allow`=1, in a transaction whose `wen_set` was 1 at `cmd_start` and with at least one byte strobed, starts programming. In the cycle after the `cs_rise` cycle, `arr_we` goes high for exactly PAGE_BYTES consecutive cycles, with offsets 0, 1, … PAGE_BYTES-1.
- R6: A `cs_rise` with `cs_rise_aligned`=0 discards the transaction: no array write, no busy, no `wen_clear`.
- R7: A transaction opened with `wen_set`=0 is discarded at `cs_rise` with no array write and no busy.
- R8: A `cs_rise` with `allow`=0 discards the transaction with no array write and no busy.
- R9: Once programming starts, `busy` stays high for exactly PAGE_BYTES+CYCLE_CLKS cycles. `wen_clear` is a single-cycle pulse in the last busy cycle.
- R10: While `busy` is high, `cmd_start`, `byte_valid` and `cs_rise` are ignored: the page write and busy length are unchanged, and no second program starts.
- R11: A `cs_rise` with no byte loaded, or with no open transaction, causes no array write and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a write command opened, address valid |
| start_addr | input | ADDR_W | Start byte address of the command |
| wen_set | input | 1 | Write-enable latch state, sampled at `cmd_start` |
| byte_valid | input | 1 | Pulse: one received data byte on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| cs_rise_aligned | input | 1 | The rise came right after the last bit of a byte |
| allow | input | 1 | Protection permits programming this page |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Program cycle in progress |
| wen_clear | output | 1 | Pulse: clear the write-enable latch |

## Verification
The hardest state to reach from the ports is a transaction that crosses the page end more than once. Here the offset has wrapped, overwritten bytes sit next to bytes never loaded, and the final image mixes last-writer data with all-ones fill. The stimulus reaches it with directed transactions that start near the top offset and push past 128 bytes, and with random transactions whose start offset and byte count are both drawn over the full range. A second hard case is new traffic arriving in the middle of a busy period. The bench injects a full command, with bytes and an aligned chip-select rise, partway through programming and checks that the write count and busy length are unchanged.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [2:0] {
    PW_IDLE,
    PW_LOAD,
    PW_SKIP,
    PW_DRAIN,
    PW_TIMED
  } pw_state_e;

  // next in-page offset after one byte, wrapping at the page size
  function automatic int unsigned wrap_next(input int unsigned off, input int unsigned size);
    return (off + 1) % size;
  endfunction

  // programming starts only on a clean, permitted, non-empty transaction
  function automatic logic go_decision(input logic aligned, input logic permitted,
                                       input logic loaded);
    return aligned & permitted & loaded;
  endfunction

endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int PAGE_BYTES = 128,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              any_loaded
);

  logic [DATA_W-1:0]     mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wr_data;
  end

  genvar g;
  generate
    for (g = 0; g < PAGE_BYTES; g++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  mask_q[g] <= 1'b0;
        else if (clr)                                mask_q[g] <= 1'b0;
        else if (wr_en && wr_off == OFF_W'(g))       mask_q[g] <= 1'b1;
      end
    end
  endgenerate

  assign rd_data    = mask_q[rd_off] ? mem[rd_off] : {DATA_W{1'b1}};
  assign any_loaded = |mask_q;

endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  output logic [OFF_W-1:0] idx,
  output logic             last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (start)  idx <= '0;
    else if (active) idx <= idx + 1'b1;
  end

  assign last = active && (idx == OFF_W'(PAGE_BYTES - 1));

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int CYCLE_CLKS = 500,
  localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == CNT_W'(CYCLE_CLKS - 1));

endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int CYCLE_CLKS = 500,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wen_set,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              cs_rise_aligned,
  input  logic              allow,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic              wen_clear
);
  import pwb_pkg::*;

  pw_state_e         state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  // named internal events
  logic             open_go;
  logic             load_go;
  logic             prog_go;
  logic             drop_go;
  logic             drain_last;
  logic             tmr_done;
  logic             any_loaded;
  logic [OFF_W-1:0] drain_idx;
  logic [DATA_W-1:0] rd_data;

  assign open_go = (state_q == PW_IDLE) && cmd_start;
  assign load_go = (state_q == PW_LOAD) && byte_valid;
  assign prog_go = (state_q == PW_LOAD) && cs_rise &&
                   go_decision(cs_rise_aligned, allow, any_loaded);
  assign drop_go = ((state_q == PW_LOAD) || (state_q == PW_SKIP)) && cs_rise && !prog_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      page_q  <= '0;
      off_q   <= '0;
    end else begin
      unique case (state_q)
        PW_IDLE: begin
          if (open_go) begin
            page_q  <= start_addr[ADDR_W-1:OFF_W];
            off_q   <= start_addr[OFF_W-1:0];
            state_q <= wen_set ? PW_LOAD : PW_SKIP;
          end
        end
        PW_LOAD: begin
          if (prog_go)      state_q <= PW_DRAIN;
          else if (drop_go) state_q <= PW_IDLE;
          else if (load_go) off_q <= OFF_W'(wrap_next(32'(off_q), PAGE_BYTES));
        end
        PW_SKIP: begin
          if (drop_go) state_q <= PW_IDLE;
        end
        PW_DRAIN: begin
          if (drain_last) state_q <= PW_TIMED;
        end
        PW_TIMED: begin
          if (tmr_done) state_q <= PW_IDLE;
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  pwb_page_store #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (open_go),
    .wr_en     (load_go && !cs_rise),
    .wr_off    (off_q),
    .wr_data   (byte_data),
    .rd_off    (drain_idx),
    .rd_data   (rd_data),
    .any_loaded(any_loaded)
  );

  pwb_drain #(
    .PAGE_BYTES(PAGE_BYTES)
  ) u_drain (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_go),
    .active(state_q == PW_DRAIN),
    .idx   (drain_idx),
    .last  (drain_last)
  );

  pwb_cycle_timer #(
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(drain_last),
    .run  (state_q == PW_TIMED),
    .done (tmr_done)
  );

  assign arr_we    = (state_q == PW_DRAIN);
  assign arr_addr  = {page_q, drain_idx};
  assign arr_data  = rd_data;
  assign busy      = (state_q == PW_DRAIN) || (state_q == PW_TIMED);
  assign wen_clear = tmr_done;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              cs_rise_aligned,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy,
  input logic              wen_clear,
  input logic              prog_go
);

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);  // R5

  AST_FIRST_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_we) |-> (arr_addr[OFF_W-1:0] == '0));  // R5

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      ((arr_addr[OFF_W-1:0] == $past(arr_addr[OFF_W-1:0]) + 1'b1) &&
       (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W]))));  // R2

  AST_BUSY_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go && cs_rise));  // R5

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cs_rise && !cs_rise_aligned) |=> !busy);  // R6

  AST_CLEAR_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clear |-> busy);  // R9

  AST_CLEAR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clear |=> (!busy && !wen_clear));  // R9

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_go);  // R10

endmodule

bind pwb_page_writer pwb_checker #(
  .ADDR_W(ADDR_W),
  .OFF_W (OFF_W)
) u_pwb_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cs_rise        (cs_rise),
  .cs_rise_aligned(cs_rise_aligned),
  .arr_we         (arr_we),
  .arr_addr       (arr_addr),
  .busy           (busy),
  .wen_clear      (wen_clear),
  .prog_go        (prog_go)
);

// File: tb/pwb_page_writer_tb.sv
module pwb_page_writer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int PAGE       = 128;
  localparam int CYC        = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              wen_set = 1'b0;
  logic              byte_valid = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic              cs_rise = 1'b0;
  logic              cs_rise_aligned = 1'b0;
  logic              allow = 1'b0;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;
  logic              busy;
  logic              wen_clear;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_page_writer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .CYCLE_CLKS(CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
    .wen_set(wen_set), .byte_valid(byte_valid), .byte_data(byte_data),
    .cs_rise(cs_rise), .cs_rise_aligned(cs_rise_aligned), .allow(allow),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .wen_clear(wen_clear)
  );

  // monitor, sampling away from the active edge
  logic [ADDR_W-1:0] got_addr [PAGE];
  logic [DATA_W-1:0] got_data [PAGE];
  int nwr, nbusy, nclr, busy_at_clr;

  always @(negedge clk) begin
    if (arr_we) begin
      if (nwr < PAGE) begin
        got_addr[nwr] = arr_addr;
        got_data[nwr] = arr_data;
      end
      nwr++;
    end
    if (busy) nbusy++;
    if (wen_clear) begin
      nclr++;
      busy_at_clr = nbusy;
    end
  end

  // bench page model
  logic [DATA_W-1:0] exp_img [PAGE];

  function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:0] a, input int k);
    return ((a / PAGE) * PAGE) + ADDR_W'(k);
  endfunction

  function automatic int step_off(input int off);
    return (off == PAGE - 1) ? 0 : off + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one transaction; poke injects traffic while busy
  task automatic txn(input logic [ADDR_W-1:0] addr, input int nbytes,
                     input bit wen, input bit aligned, input bit alw,
                     input bit poke, input string req);
    int off;
    bit expect_prog;
    nwr = 0; nbusy = 0; nclr = 0; busy_at_clr = 0;
    for (int k = 0; k < PAGE; k++) exp_img[k] = 8'hFF;
    off = int'(addr % PAGE);
    cmd_start = 1'b1; start_addr = addr; wen_set = wen;
    tick();
    cmd_start = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      repeat ($urandom_range(0, 2)) tick();
      byte_valid = 1'b1;
      byte_data  = DATA_W'($urandom);
      exp_img[off] = byte_data;
      off = step_off(off);
      tick();
      byte_valid = 1'b0;
    end
    cs_rise = 1'b1; cs_rise_aligned = aligned; allow = alw;
    tick();
    cs_rise = 1'b0;
    if (poke) begin
      repeat (20) tick();
      cmd_start = 1'b1; start_addr = addr + 16'd300; wen_set = 1'b1;
      tick();
      cmd_start = 1'b0; byte_valid = 1'b1; byte_data = 8'h5A;
      tick();
      byte_valid = 1'b0; cs_rise = 1'b1; cs_rise_aligned = 1'b1; allow = 1'b1;
      tick();
      cs_rise = 1'b0;
    end
    repeat (PAGE + CYC + 8) tick();
    expect_prog = wen && aligned && alw && (nbytes > 0);
    if (expect_prog) begin
      check(nwr == PAGE, req, "array write count", nwr, PAGE);
      for (int k = 0; k < PAGE && k < nwr; k++) begin
        check(got_addr[k] == page_addr(addr, k), "R2", "array address", got_addr[k],
              page_addr(addr, k));
        check(got_data[k] == exp_img[k], "R3/R4", "array data", got_data[k], exp_img[k]);
      end
      check(nbusy == PAGE + CYC, "R9", "busy length", nbusy, PAGE + CYC);
      check(nclr == 1, "R9", "wen_clear pulses", nclr, 1);
      check(busy_at_clr == PAGE + CYC, "R9", "wen_clear position", busy_at_clr, PAGE + CYC);
    end else begin
      check(nwr == 0, req, "array writes on discard", nwr, 0);
      check(nbusy == 0, req, "busy on discard", nbusy, 0);
      check(nclr == 0, req, "wen_clear on discard", nclr, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(arr_we == 1'b0, "R1", "arr_we after reset", arr_we, 0);
    check(wen_clear == 1'b0, "R1", "wen_clear after reset", wen_clear, 0);
    rst_n = 1'b1;
    tick();

    txn(16'h1200, 128, 1, 1, 1, 0, "R5");        // full page from offset 0
    txn(16'h34F8, 10, 1, 1, 1, 0, "R2");         // wraps 120..127 then 0..1, R4 fill
    txn(16'h7F10, 130, 1, 1, 1, 0, "R3");        // overwrite beyond the page
    txn(16'h0005, 300, 1, 1, 1, 0, "R3");        // multiple wraps
    txn(16'h2222, 5, 1, 0, 1, 0, "R6");          // misaligned rise
    txn(16'h4400, 20, 0, 1, 1, 0, "R7");         // write-enable not set
    txn(16'h6600, 20, 1, 1, 0, 0, "R8");         // protection refuses
    txn(16'h0A00, 0, 1, 1, 1, 0, "R11");         // nothing loaded
    txn(16'hC080, 64, 1, 1, 1, 1, "R10");        // traffic during busy ignored

    // rise with no open transaction: R11
    nwr = 0; nbusy = 0;
    cs_rise = 1'b1; cs_rise_aligned = 1'b1; allow = 1'b1;
    tick();
    cs_rise = 1'b0;
    repeat (10) tick();
    check(nwr == 0 && nbusy == 0, "R11", "idle rise activity", nwr + nbusy, 0);

    for (int t = 0; t < 12; t++) begin
      txn(ADDR_W'($urandom), $urandom_range(0, 260), ($urandom_range(0, 7) != 0),
          ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0), 0, "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule